// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block configures a downstream FPGA through a byte-wide write port. A single `start` pulse begins the load. The block pulses the active-low program line to clear the target. It then waits for the active-low init line to be released, guarded by a programmable cycle timeout. Once the target is ready, the block writes a fixed eight-byte header, followed by framed payload chunks of 21 bytes and four startup bytes. Payload bytes arrive on a valid/ready stream. The block adds every framing byte itself, so the stream carries only raw bitstream data.

Each byte leaves on `wr_data` together with a one-cycle `wr_en` strobe. A run-time gap input sets the minimum number of idle cycles between strobes, to suit the target's write timing. Before each frame the block samples the synchronised init and done pins. A new frame begins only when the target is still healthy and payload remains. When the load ends, exactly one of three sticky flags reports the outcome: success, error or init timeout. The flags hold until the next start.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, and whenever idle, `cfg_prog_n` is high, `wr_en` and `s_ready` are low, `busy` is low and all three result flags are low. The flags keep their value while idle until the next `start`.
- R2: A `start` while idle drives `cfg_prog_n` low for exactly RST_CYCLES clock cycles, then high. No write strobe occurs while it is low.
- R3: After the program pulse, no byte is written until the synchronised `cfg_init_n` is high. If it stays low for `init_timeout` cycles, `init_tmo` is set, `busy` falls and no byte is written.
- R4: The header is written first, in this order: FF, FF, FF, 4F, 80, AF, 9B, 4B (hex).
- R5: Each frame is 28 bytes in this order: 4F, 21 payload bytes, 4B, FF, 4B, FF, FF, FF.
- R6: A stream byte is taken (`s_valid` and `s_ready` high at a clock edge) only at one of the 21 payload positions of a frame, and only while fewer than `payload_len` bytes have been taken. A payload position beyond `payload_len` is written as FF without taking a byte.
- R7: Before each frame the block requires synchronised init high, done low and payload remaining. If any of these fails, it goes straight to the startup bytes.
- R8: After the header and any frames, exactly four FF startup bytes are written, and the load ends.
- R9: At the end of the load, `load_ok` is set if all `payload_len` bytes were written and done is high. Otherwise `load_err` is set. At most one of the three flags is ever high.
- R10: `wr_en` is high for single cycles only. At least `gap_cycles` idle cycles separate any two strobes of a load.
- R11: A `start` pulse during a load has no effect on the byte sequence or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (ignored while busy) |
| payload_len | input | LEN_W | Number of payload bytes in the bitstream |
| gap_cycles | input | GAP_W | Minimum idle cycles between write strobes |
| init_timeout | input | TO_W | Cycles to wait for init release before giving up |
| cfg_prog_n | output | 1 | Active-low program/clear line to the target |
| cfg_init_n | input | 1 | Target init line, low while not ready (asynchronous) |
| cfg_done | input | 1 | Target done line (asynchronous) |
| s_valid | input | 1 | Payload stream byte valid |
| s_ready | output | 1 | Payload stream byte taken this cycle when valid |
| s_data | input | 8 | Payload stream byte |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Byte written with the strobe |
| busy | output | 1 | Load in progress |
| load_ok | output | 1 | Last load completed successfully |
| load_err | output | 1 | Last load failed (payload short or done low) |
| init_tmo | output | 1 | Last load timed out waiting for init |

## Verification
The checker watches several properties on every cycle. It confirms that no strobe appears while the program line is low and that the low pulse never runs past its length. It checks the minimum strobe spacing, that stream handshakes only happen during a load, that the result flags are mutually exclusive, and that the idle state holds steady. Other behaviour depends on the order of bytes and on how the target pins move, so only the bench scenarios can show it. These cover the exact header, frame and pad contents, and the decision to skip frames when init drops or done is already high. They also cover the choice between success and error, the timeout path, and the number of stream bytes actually taken.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam logic [7:0] B_FILL = 8'hFF;
    localparam logic [7:0] B_PRE  = 8'h4F;
    localparam logic [7:0] B_CHK  = 8'h4B;

    localparam int HDR_LEN   = 8;
    localparam int FRM_LEN   = 28;
    localparam int PAY_FIRST = 1;
    localparam int PAY_LEN   = 21;
    localparam int STUP_LEN  = 4;
    localparam int IDX_W     = $clog2(FRM_LEN);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RESET,
        PH_WAIT,
        PH_HDR,
        PH_CHK,
        PH_FRM,
        PH_START,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic [7:0] data;
        logic       is_pay;
        logic       last;
    } slot_t;

    function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] i);
        case (i)
            IDX_W'(3): return B_PRE;
            IDX_W'(4): return 8'h80;
            IDX_W'(5): return 8'hAF;
            IDX_W'(6): return 8'h9B;
            IDX_W'(7): return B_CHK;
            default:   return B_FILL;
        endcase
    endfunction

    function automatic logic [7:0] frm_byte(input logic [IDX_W-1:0] i);
        case (i)
            IDX_W'(0):  return B_PRE;
            IDX_W'(22): return B_CHK;
            IDX_W'(24): return B_CHK;
            default:    return B_FILL;
        endcase
    endfunction

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= {STAGES{RST_VAL}};
                else     sr <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr <= {STAGES{RST_VAL}};
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cfgld_gap_timer.sv
module cfgld_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] gap,
    output logic             ready
);
    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= gap;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign ready = (cnt == '0);
endmodule

// File: rtl/cfgld_byte_sel.sv
module cfgld_byte_sel
    import cfgld_pkg::*;
(
    input  phase_e           phase,
    input  logic [IDX_W-1:0] idx,
    output slot_t            slot
);
    always_comb begin
        slot        = '0;
        slot.data   = B_FILL;
        case (phase)
            PH_HDR: begin
                slot.data = hdr_byte(idx);
                slot.last = (idx == IDX_W'(HDR_LEN - 1));
            end
            PH_FRM: begin
                slot.data   = frm_byte(idx);
                slot.is_pay = (idx >= IDX_W'(PAY_FIRST)) &&
                              (idx <= IDX_W'(PAY_FIRST + PAY_LEN - 1));
                slot.last   = (idx == IDX_W'(FRM_LEN - 1));
            end
            PH_START: begin
                slot.last = (idx == IDX_W'(STUP_LEN - 1));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int GAP_W       = 4,
    parameter int TO_W        = 20,
    parameter int RST_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] payload_len,
    input  logic [GAP_W-1:0] gap_cycles,
    input  logic [TO_W-1:0]  init_timeout,
    output logic             cfg_prog_n,
    input  logic             cfg_init_n,
    input  logic             cfg_done,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_data,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             busy,
    output logic             load_ok,
    output logic             load_err,
    output logic             init_tmo
);
    localparam int RST_W = $clog2(RST_CYCLES + 1);
    localparam int CNT_W = (TO_W > RST_W) ? TO_W : RST_W;

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] rem;
    slot_t            slot;
    logic             init_rdy, done_s;
    logic             gap_ready, emit_phase, have_rem, take_pos;
    logic             fire, consume;
    logic [7:0]       byte_out;
    logic             prog_n_q, wr_en_q, ok_q, err_q, tmo_q;
    logic [7:0]       wr_data_q;

    cfgld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_init (
        .clk(clk), .rst(rst), .d(cfg_init_n), .q(init_rdy)
    );

    cfgld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
        .clk(clk), .rst(rst), .d(cfg_done), .q(done_s)
    );

    cfgld_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .load(fire), .gap(gap_cycles), .ready(gap_ready)
    );

    cfgld_byte_sel u_sel (
        .phase(phase), .idx(idx), .slot(slot)
    );

    always_comb begin
        emit_phase = (phase == PH_HDR) || (phase == PH_FRM) || (phase == PH_START);
        have_rem   = (rem != '0);
        take_pos   = slot.is_pay && have_rem;
        fire       = emit_phase && gap_ready && (!take_pos || s_valid);
        consume    = fire && take_pos;
        byte_out   = take_pos ? s_data : slot.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            cnt   <= '0;
            rem   <= '0;
            ok_q  <= 1'b0;
            err_q <= 1'b0;
            tmo_q <= 1'b0;
        end else begin
            if (consume) rem <= rem - 1'b1;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_RESET;
                        rem   <= payload_len;
                        cnt   <= '0;
                        ok_q  <= 1'b0;
                        err_q <= 1'b0;
                        tmo_q <= 1'b0;
                    end
                end
                PH_RESET: begin
                    if (cnt == CNT_W'(RST_CYCLES - 1)) begin
                        phase <= PH_WAIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (init_rdy) begin
                        phase <= PH_HDR;
                        idx   <= '0;
                    end else if (cnt == CNT_W'(init_timeout)) begin
                        phase <= PH_IDLE;
                        tmo_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HDR, PH_FRM, PH_START: begin
                    if (fire) begin
                        if (slot.last) begin
                            idx   <= '0;
                            phase <= (phase == PH_START) ? PH_FIN : PH_CHK;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_CHK: begin
                    idx   <= '0;
                    phase <= (init_rdy && !done_s && have_rem) ? PH_FRM : PH_START;
                end
                PH_FIN: begin
                    ok_q  <= !have_rem && done_s;
                    err_q <= have_rem || !done_s;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_n_q  <= 1'b1;
            wr_en_q   <= 1'b0;
            wr_data_q <= 8'h00;
        end else begin
            prog_n_q  <= !((phase == PH_IDLE && start) ||
                           (phase == PH_RESET && cnt != CNT_W'(RST_CYCLES - 1)));
            wr_en_q   <= fire;
            if (fire) wr_data_q <= byte_out;
        end
    end

    assign cfg_prog_n = prog_n_q;
    assign s_ready    = (phase == PH_FRM) && gap_ready && take_pos;
    assign wr_en      = wr_en_q;
    assign wr_data    = wr_data_q;
    assign busy       = (phase != PH_IDLE);
    assign load_ok    = ok_q;
    assign load_err   = err_q;
    assign init_tmo   = tmo_q;
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int RST_CYCLES = 16,
    parameter int GAP_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [GAP_W-1:0] gap_cycles,
    input logic             cfg_prog_n,
    input logic             s_ready,
    input logic             wr_en,
    input logic             busy,
    input logic             load_ok,
    input logic             load_err,
    input logic             init_tmo
);
    logic [15:0]    low_cnt;
    logic [GAP_W:0] since;
    logic           seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            since   <= '0;
            seen    <= 1'b0;
        end else begin
            if (!cfg_prog_n && low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
            else if (cfg_prog_n)                    low_cnt <= '0;
            if (wr_en) begin
                since <= '0;
                seen  <= 1'b1;
            end else if (since != {(GAP_W+1){1'b1}}) begin
                since <= since + 1'b1;
            end
        end
    end

    p_no_write_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_prog_n |-> !wr_en);

    p_prog_width_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_prog_n |-> (32'(low_cnt) < RST_CYCLES));

    p_strobe_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && seen) |-> (since >= {1'b0, gap_cycles}));

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({load_ok, load_err, init_tmo}) <= 1);

    p_tmo_idle_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(init_tmo) |-> !busy);

    p_ready_in_load_r6: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (busy && cfg_prog_n));

    p_stay_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

    p_flags_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({load_ok, load_err, init_tmo}));
endmodule

bind fpga_cfg_loader cfgld_checker #(.RST_CYCLES(RST_CYCLES), .GAP_W(GAP_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .gap_cycles(gap_cycles),
    .cfg_prog_n(cfg_prog_n), .s_ready(s_ready), .wr_en(wr_en), .busy(busy),
    .load_ok(load_ok), .load_err(load_err), .init_tmo(init_tmo)
);

// File: tb/fpga_cfg_loader_tb.sv
module fpga_cfg_loader_tb;
    localparam int RST = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] payload_len = '0;
    logic [3:0]  gap_cycles = '0;
    logic [19:0] init_timeout = 20'd1000;
    logic        cfg_prog_n, cfg_init_n, cfg_done;
    logic        s_valid, s_ready, wr_en, busy, load_ok, load_err, init_tmo;
    logic [7:0]  s_data, wr_data;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, strobes = 0, low_cnt = 0, last_cyc = 0;
    bit have_last = 0;
    int gap_now = 0;
    int init_delay = 30, init_cnt = 0, drop_at = 0, done_at = 0;
    bit done_init = 0, dropped = 0;
    int pay_idx = 0, pay_total = 0;
    bit stall = 0, tog = 0, fire_p = 0;
    logic [7:0] exp_q[$];

    initial begin
        cfg_init_n = 1'b0;
        cfg_done   = 1'b0;
        s_valid    = 1'b0;
        s_data     = 8'h00;
    end

    always #2 clk = ~clk;

    fpga_cfg_loader #(.RST_CYCLES(RST)) u_dut (
        .clk(clk), .rst(rst), .start(start), .payload_len(payload_len),
        .gap_cycles(gap_cycles), .init_timeout(init_timeout),
        .cfg_prog_n(cfg_prog_n), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
        .load_ok(load_ok), .load_err(load_err), .init_tmo(init_tmo)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) % 256);
    endfunction

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor (scoreboard pop) and target pin model
    always @(negedge clk) begin
        cyc++;
        if (!cfg_prog_n) low_cnt++;
        if (wr_en) begin
            strobes++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 extra strobe", wr_data, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(wr_data == e, "R4 R5 R6 byte sequence", wr_data, e);
            end
            if (have_last)
                check(cyc - last_cyc >= gap_now + 1, "R10 strobe spacing", cyc - last_cyc, gap_now + 1);
            last_cyc  = cyc;
            have_last = 1;
        end
        if (!cfg_prog_n) begin
            cfg_init_n = 1'b0;
            init_cnt   = 0;
        end else if (!dropped && init_delay >= 0) begin
            if (init_cnt == init_delay) cfg_init_n = 1'b1;
            else init_cnt++;
        end
        if (drop_at != 0 && strobes == drop_at) begin
            dropped    = 1;
            cfg_init_n = 1'b0;
        end
        cfg_done = done_init || (done_at != 0 && strobes >= done_at);
    end

    // Payload stream driver
    initial begin
        forever begin
            @(negedge clk);
            if (fire_p) pay_idx++;
            tog     = !tog;
            s_valid = (pay_idx < pay_total) && (!stall || tog);
            s_data  = pat(pay_idx);
            #1;
            fire_p  = s_valid && s_ready;
        end
    end

    task automatic run_load(input string tag, input int len, input int gp, input int tlim,
                            input int idel, input int dat, input int drop, input bit dinit,
                            input bit stl, input int frames, input bit ex_ok,
                            input bit ex_err, input bit ex_tmo, input bit poke);
        int taken;
        @(negedge clk);
        payload_len  = 16'(len);
        gap_cycles   = 4'(gp);
        gap_now      = gp;
        init_timeout = 20'(tlim);
        init_delay   = idel;
        done_at      = dat;
        drop_at      = drop;
        done_init    = dinit;
        dropped      = 0;
        stall        = stl;
        strobes      = 0;
        low_cnt      = 0;
        have_last    = 0;
        pay_idx      = 0;
        pay_total    = len;
        exp_q.delete();
        if (!ex_tmo) begin
            exp_q.push_back(8'hFF); exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
            exp_q.push_back(8'h4F); exp_q.push_back(8'h80); exp_q.push_back(8'hAF);
            exp_q.push_back(8'h9B); exp_q.push_back(8'h4B);
            for (int f = 0; f < frames; f++) begin
                exp_q.push_back(8'h4F);
                for (int k = 0; k < 21; k++)
                    exp_q.push_back((f * 21 + k < len) ? pat(f * 21 + k) : 8'hFF);
                exp_q.push_back(8'h4B); exp_q.push_back(8'hFF); exp_q.push_back(8'h4B);
                exp_q.push_back(8'hFF); exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
            end
            for (int k = 0; k < 4; k++) exp_q.push_back(8'hFF);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            payload_len = 16'(len + 21);   // R11: must not affect the running load
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            payload_len = 16'(len);
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        taken = (len < frames * 21) ? len : frames * 21;
        check(exp_q.size() == 0, {"R8 all bytes written ", tag}, exp_q.size(), 0);
        check(low_cnt == RST, {"R2 program pulse width ", tag}, low_cnt, RST);
        check(cfg_prog_n == 1'b1, {"R2 program released ", tag}, cfg_prog_n, 1);
        check(pay_idx == taken, {"R6 stream bytes taken ", tag}, pay_idx, taken);
        check(load_ok == ex_ok, {"R9 ok flag ", tag}, load_ok, ex_ok);
        check(load_err == ex_err, {"R9 err flag ", tag}, load_err, ex_err);
        check(init_tmo == ex_tmo, {"R3 timeout flag ", tag}, init_tmo, ex_tmo);
        check(busy == 1'b0, {"R1 idle after load ", tag}, busy, 0);
        if (ex_tmo) check(strobes == 0, {"R3 no writes on timeout ", tag}, strobes, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset / idle state
        check(cfg_prog_n == 1'b1, "R1 prog high at reset", cfg_prog_n, 1);
        check(wr_en == 1'b0, "R1 no strobe at reset", wr_en, 0);
        check(s_ready == 1'b0, "R1 no ready at reset", s_ready, 0);
        check(busy == 1'b0, "R1 idle at reset", busy, 0);
        check({load_ok, load_err, init_tmo} == 3'b000, "R1 flags clear", {load_ok, load_err, init_tmo}, 0);

        // R5 R9: two full frames, success
        run_load("full",    42, 2, 1000, 30, 64, 0, 0, 0, 2, 1, 0, 0, 0);
        // R6: partial last frame padded, stalled stream, no gap
        run_load("partial", 25, 0, 1000, 30, 64, 0, 0, 1, 2, 1, 0, 0, 0);
        // R7 R9: zero length with done already high -> success, no frames
        run_load("empty",    0, 1, 1000, 30, 0, 0, 1, 0, 0, 1, 0, 0, 0);
        // R7: init drops during header -> no frames, error
        run_load("initdrop", 63, 3, 1000, 30, 0, 4, 0, 0, 0, 0, 1, 0, 0);
        // R7: done high before any frame -> no frames, error
        run_load("doneearly", 42, 1, 1000, 30, 0, 0, 1, 0, 0, 0, 1, 0, 0);
        // R9: done never rises -> error after full payload
        run_load("nodone",  21, 1, 1000, 30, 0, 0, 0, 0, 1, 0, 1, 0, 0);
        // R3: init never released -> timeout
        run_load("timeout", 21, 1, 50, -1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R11: start pulse during load ignored
        run_load("restart", 42, 1, 1000, 30, 64, 0, 0, 1, 2, 1, 0, 0, 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule